// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the fetch address for an instruction memory that holds one 32-bit instruction per word. It keeps two registers: the address being fetched now and the address to fetch after it. Without a branch, both move forward by one word each cycle. A taken branch does not redirect the fetch at once. The target goes into the second register, and the instruction that follows the branch, called the delay slot, is always fetched and issued before the fetch reaches the target.

The pipeline drives a fetch enable. When it is low, the sequencer holds its state and marks the current fetch invalid. When it is high, the pipeline may also raise a branch-taken strobe for the instruction being issued in that cycle, together with its target. A target that is not word aligned is flagged and discarded, and sequential fetch continues. A branch that is itself in a delay slot needs no special case: the second target simply queues behind the first.

Top module: `fetch_seq`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and in the first cycle after it, the fetch address is BOOT_ADDR (default 0), the delay-slot flag is 0 and the misalignment flag is 0.
- R2: In a cycle with the enable high, no taken branch and the current instruction not a delay slot, the next fetch address is the current one plus 4.
- R3: The fetch address always has its low two bits equal to zero.
- R4: A taken branch with an aligned target, issued while the enable is high, makes the next fetch the current address plus 4 (the delay slot). The fetch after that is the target.
- R5: A taken branch issued from a delay slot makes the fetch after the delay slot's successor go to the second target. The first target is still fetched, directly after the delay slot.
- R6: While the enable is low, the fetch address and the delay-slot flag keep their values, and the valid output is 0. When the enable is high, valid is 1.
- R7: When the enable and the branch strobe are high and the target's low two bits are not 00, the misalignment output is 1 in that same cycle. The target is not loaded, and fetch continues as if no branch were taken.
- R8: A branch strobe raised while the enable is low has no effect on later fetch addresses and does not raise the misalignment output.
- R9: The delay-slot output is 1 exactly when the current fetch address is the instruction right after an accepted taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | 1 = issue the current fetch and advance, 0 = stall |
| br_take | input | 1 | Branch taken by the instruction issued this cycle |
| br_target | input | AW | Branch target byte address |
| fetch_addr | output | AW | Current fetch byte address |
| fetch_valid | output | 1 | Current fetch is issued this cycle |
| in_delay_slot | output | 1 | Current fetch is a delay-slot instruction |
| misalign | output | 1 | Taken branch this cycle has an unaligned target |

## Verification
The case that stresses the design most is a taken branch issued while the current instruction is itself a delay slot, so that loading a new target and draining a pending one fall in the same cycle. The bench provokes this by sweeping every 4-bit pattern of taken/not-taken over four consecutive issued cycles, with a distinct target per cycle, and stalls are mixed in as well. An arithmetic model of the current/next address pair, written from the requirements, judges each fetched address. The other overlap, a stall together with a branch strobe, is checked by requiring that the address sequence is unchanged and that no misalignment is reported.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BOOT_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en,
  input  logic          br_take,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_valid,
  output logic          in_delay_slot,
  output logic          misalign
);

  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] pc_q, npc_q;
  logic          slot_q;

  wire tgt_ok   = (br_target[1:0] == 2'b00);
  wire redirect = fetch_en & br_take & tgt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= BOOT_ADDR;
      npc_q  <= BOOT_ADDR + STEP;
      slot_q <= 1'b0;
    end else if (fetch_en) begin
      pc_q   <= npc_q;
      npc_q  <= redirect ? br_target : npc_q + STEP;
      slot_q <= redirect;
    end
  end

  assign fetch_addr    = pc_q;
  assign fetch_valid   = fetch_en & rst_n;
  assign in_delay_slot = slot_q;
  assign misalign      = fetch_en & br_take & ~tgt_ok & rst_n;

  always_comb begin
    if (rst_n) AST_ADDR_ALIGNED: assert (fetch_addr[1:0] == 2'b00); // R3
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !in_delay_slot) |=> fetch_addr == $past(fetch_addr) + STEP); // R2

  AST_SLOT_AFTER_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && br_take && br_target[1:0] == 2'b00) |=> in_delay_slot); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> ($stable(fetch_addr) && $stable(in_delay_slot))); // R6

  AST_BAD_TARGET_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> !in_delay_slot); // R7

  AST_NO_FLAG_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |-> (!misalign && !fetch_valid)); // R8

endmodule

// File: tb/sim_fetch_seq.sv
module sim_fetch_seq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_en = 1'b0;
  logic          br_take = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic [AW-1:0] fetch_addr;
  logic          fetch_valid, in_delay_slot, misalign;

  always #2.5 clk = ~clk;

  fetch_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .br_take(br_take),
    .br_target(br_target), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
    .in_delay_slot(in_delay_slot), .misalign(misalign)
  );

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] m_pc, m_npc;
  logic          m_ds;
  string         tag;

  task automatic chk(input string t, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic take, input logic [AW-1:0] tgt);
    logic ok;
    @(negedge clk);
    fetch_en = en; br_take = take; br_target = tgt;
    #1;
    ok = (tgt[1:0] == 2'b00);
    chk(tag, "addr", fetch_addr, m_pc);
    chk("R3", "addr_low", {30'd0, fetch_addr[1:0]}, '0);
    chk("R9", "delay_slot", {31'd0, in_delay_slot}, {31'd0, m_ds});
    chk("R6", "valid", {31'd0, fetch_valid}, {31'd0, en});
    chk(en ? "R7" : "R8", "misalign", {31'd0, misalign}, {31'd0, en & take & ~ok});
    @(posedge clk);
    if (en) begin
      m_pc  = m_npc;
      m_npc = (take && ok) ? tgt : m_npc + 4;
      m_ds  = take && ok;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_pc = '0; m_npc = 32'd4; m_ds = 1'b0;
    #7;
    chk("R1", "reset_addr", fetch_addr, '0);
    chk("R1", "reset_slot", {31'd0, in_delay_slot}, '0);
    chk("R1", "reset_misalign", {31'd0, misalign}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R2";
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, '0);

    tag = "R6";
    for (int i = 0; i < 8; i++) cyc(i[0], 1'b0, '0);

    tag = "R4";
    cyc(1'b1, 1'b1, 32'h0000_0100);
    cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b1, 32'h0000_0040);
    cyc(1'b0, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);

    tag = "R7";
    for (int b = 1; b < 4; b++) begin
      cyc(1'b1, 1'b1, 32'h0000_0200 + b);
      cyc(1'b1, 1'b0, '0);
    end

    tag = "R8";
    cyc(1'b0, 1'b1, 32'h0000_0800);
    cyc(1'b0, 1'b1, 32'h0000_0801);
    cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);

    tag = "R5";
    cyc(1'b1, 1'b1, 32'h0000_1000);
    cyc(1'b1, 1'b1, 32'h0000_2000);
    cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);

    for (int mask = 0; mask < 16; mask++) begin
      for (int st = 0; st < 2; st++) begin
        for (int k = 0; k < 4; k++) begin
          if (st == 1 && k == 2) cyc(1'b0, 1'b1, 32'h0000_0003);
          cyc(1'b1, mask[k], 32'h0001_0000 + (mask << 8) + (k << 4) + (st << 12));
        end
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, '0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule